// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block accepts one interrupt delivery request at a time and turns it into a sequence of injections aimed at a table of local interrupt-controller slots. A request carries an 8-bit destination, a one-bit addressing mode (physical or logical), a 3-bit delivery mode, a vector and a trigger-mode bit. Each slot of the table carries a present flag, a physical ID and a logical ID. All three are supplied as flat input vectors by the surrounding logic. The table is sampled only in the cycle a request is accepted.

From the destination and the table the block forms a target set. Physical addressing selects a single slot, or every present slot when the destination is all ones. Logical addressing selects every present slot whose logical ID shares a set bit with the destination. In fixed delivery mode every target receives the interrupt, one at a time in ascending slot order. In lowest-priority mode exactly one target receives it. That target is found by a rotating search that starts at a pointer, and the pointer then moves past the chosen slot. Injections leave on a valid/ready channel that carries the slot number, the vector and the trigger bit. The request side is blocked while injections are still pending.

Top module: `irq_dest_dispatch`

## Requirements
- R1: After reset `out_valid` is 0, `req_ready` is 1 and the rotation pointer is at slot 0. The first lowest-priority request therefore picks the lowest-numbered target.
- R2: In physical mode (`req_logical`=0), destination 0xFF targets every slot whose present bit is set.
- R3: In physical mode with any other destination, the target set is only the lowest-numbered present slot whose physical ID equals the destination. Absent slots never match.
- R4: In logical mode (`req_logical`=1), destination 0 targets nothing. Any other destination targets every present slot whose logical ID ANDed with the destination is non-zero.
- R5: A request whose target set is empty is accepted and produces no injection, and `req_ready` stays 1.
- R6: Delivery mode 3'b000 (fixed) produces one injection per target, in ascending slot order. Each injection carries the request's vector and trigger bit.
- R7: Delivery mode 3'b001 (lowest priority) produces exactly one injection. It goes to the first target found at or above the rotation pointer, wrapping past the top slot. The pointer then becomes the chosen slot plus one, modulo the slot count.
- R8: Delivery modes 3'b010 through 3'b111 are accepted and dropped with no injection.
- R9: `req_ready` is 0 from the cycle after acceptance of a request that injects until the handshake of its last injection. It is 1 in the cycle after that handshake.
- R10: While `out_valid` is 1 and `out_ready` is 0, the slot, vector and trigger outputs hold their values.
- R11: The first injection of a request is valid in the cycle right after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Delivery request present |
| req_ready | output | 1 | Block can accept a request |
| req_dest | input | ID_W | Destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_dmode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, others dropped |
| req_vector | input | VEC_W | Interrupt vector |
| req_level | input | 1 | Trigger mode carried to the output |
| slot_present | input | NUM_SLOTS | Slot present flags |
| slot_phys_id | input | NUM_SLOTS*ID_W | Physical IDs, slot i at bits i*ID_W upward |
| slot_log_id | input | NUM_SLOTS*ID_W | Logical IDs, slot i at bits i*ID_W upward |
| out_valid | output | 1 | Injection present |
| out_ready | input | 1 | Receiver takes the injection |
| out_slot | output | SLOT_W | Target slot number |
| out_vector | output | VEC_W | Vector of the injection |
| out_level | output | 1 | Trigger mode of the injection |

## Verification
A request accepted on one rising edge shows its first injection on the very next cycle. Each later injection of a fixed fan-out appears on the cycle after the previous one is taken. `req_ready` returns one cycle after the last injection is taken. The bench keeps a queue of expected injections that is updated on the same edges as the design, from the inputs it drove at the previous falling edge. It compares every output at each falling edge, so every one of these latencies is checked exactly. `out_ready` is stalled at random to exercise the hold rule.

// File: rtl/irq_dd_pkg.sv
package irq_dd_pkg;
  localparam int DMODE_W = 3;
  localparam logic [DMODE_W-1:0] DMODE_FIXED  = 3'b000;
  localparam logic [DMODE_W-1:0] DMODE_LOWEST = 3'b001;
endpackage

// File: rtl/irq_dd_target_mask.sv
module irq_dd_target_mask #(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 8
) (
  input  logic [ID_W-1:0]           dest,
  input  logic                      logical,
  input  logic [NUM_SLOTS-1:0]      present,
  input  logic [NUM_SLOTS*ID_W-1:0] phys_ids,
  input  logic [NUM_SLOTS*ID_W-1:0] log_ids,
  output logic [NUM_SLOTS-1:0]      mask
);
  logic [NUM_SLOTS-1:0] phys_hit;
  logic [NUM_SLOTS-1:0] log_hit;
  logic [NUM_SLOTS-1:0] phys_first;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign phys_hit[i] = present[i] && (phys_ids[i*ID_W +: ID_W] == dest);
    assign log_hit[i]  = present[i] && ((log_ids[i*ID_W +: ID_W] & dest) != '0);
  end

  // keep only the lowest-numbered physical hit
  always_comb begin
    logic seen;
    seen       = 1'b0;
    phys_first = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (phys_hit[i] && !seen) begin
        phys_first[i] = 1'b1;
        seen          = 1'b1;
      end
    end
  end

  always_comb begin
    if (logical)
      mask = (dest == '0) ? '0 : log_hit;
    else
      mask = (dest == '1) ? present : phys_first;
  end
endmodule

// File: rtl/irq_dd_rr_pick.sv
module irq_dd_rr_pick #(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = 4
) (
  input  logic [NUM_SLOTS-1:0] cand,
  input  logic [SLOT_W-1:0]    ptr,
  output logic                 found,
  output logic [SLOT_W-1:0]    pick
);
  always_comb begin
    int idx;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      idx = int'(ptr) + k;
      if (idx >= NUM_SLOTS) idx = idx - NUM_SLOTS;
      if (!found && cand[idx]) begin
        found = 1'b1;
        pick  = SLOT_W'(idx);
      end
    end
  end
endmodule

// File: rtl/irq_dest_dispatch.sv
module irq_dest_dispatch
  import irq_dd_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ID_W      = 8,
  parameter int VEC_W     = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ID_W-1:0]           req_dest,
  input  logic                      req_logical,
  input  logic [DMODE_W-1:0]        req_dmode,
  input  logic [VEC_W-1:0]          req_vector,
  input  logic                      req_level,
  input  logic [NUM_SLOTS-1:0]      slot_present,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_phys_id,
  input  logic [NUM_SLOTS*ID_W-1:0] slot_log_id,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [SLOT_W-1:0]         out_slot,
  output logic [VEC_W-1:0]          out_vector,
  output logic                      out_level
);
  function automatic logic [SLOT_W-1:0] lowest_idx(input logic [NUM_SLOTS-1:0] m);
    lowest_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (m[i]) lowest_idx = SLOT_W'(i);
  endfunction

  function automatic logic [NUM_SLOTS-1:0] onehot(input logic [SLOT_W-1:0] idx);
    onehot = '0;
    onehot[idx] = 1'b1;
  endfunction

  function automatic logic [SLOT_W-1:0] after(input logic [SLOT_W-1:0] idx);
    after = (idx == SLOT_W'(NUM_SLOTS - 1)) ? '0 : idx + 1'b1;
  endfunction

  logic [NUM_SLOTS-1:0] pend_mask;
  logic [VEC_W-1:0]     vec_q;
  logic                 lvl_q;
  logic [SLOT_W-1:0]    rr_ptr;

  logic [NUM_SLOTS-1:0] tgt_mask;
  logic                 rr_found;
  logic [SLOT_W-1:0]    rr_pick;
  logic                 accept, out_fire, is_fixed, is_lowest;
  logic [SLOT_W-1:0]    head_slot;

  irq_dd_target_mask #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_mask (
    .dest     (req_dest),
    .logical  (req_logical),
    .present  (slot_present),
    .phys_ids (slot_phys_id),
    .log_ids  (slot_log_id),
    .mask     (tgt_mask)
  );

  irq_dd_rr_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_rr (
    .cand  (tgt_mask),
    .ptr   (rr_ptr),
    .found (rr_found),
    .pick  (rr_pick)
  );

  assign is_fixed  = (req_dmode == DMODE_FIXED);
  assign is_lowest = (req_dmode == DMODE_LOWEST);
  assign req_ready = (pend_mask == '0);
  assign accept    = req_valid && req_ready;
  assign out_valid = |pend_mask;
  assign out_fire  = out_valid && out_ready;
  assign head_slot = lowest_idx(pend_mask);

  assign out_slot   = head_slot;
  assign out_vector = vec_q;
  assign out_level  = lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mask <= '0;
      vec_q     <= '0;
      lvl_q     <= 1'b0;
      rr_ptr    <= '0;
    end else if (accept) begin
      vec_q <= req_vector;
      lvl_q <= req_level;
      if (is_fixed)
        pend_mask <= tgt_mask;
      else if (is_lowest && rr_found)
        pend_mask <= onehot(rr_pick);
      else
        pend_mask <= '0;
      if (is_lowest && rr_found)
        rr_ptr <= after(rr_pick);
    end else if (out_fire) begin
      pend_mask <= pend_mask & ~onehot(head_slot);
    end
  end
endmodule

// File: rtl/irq_dd_checker.sv
module irq_dd_checker #(
  parameter int NUM_SLOTS = 16,
  parameter int VEC_W     = 8,
  parameter int SLOT_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic                 is_fixed,
  input logic                 is_lowest,
  input logic [NUM_SLOTS-1:0] tgt_mask,
  input logic [NUM_SLOTS-1:0] pend_mask,
  input logic                 req_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic                 out_fire,
  input logic [SLOT_W-1:0]    out_slot,
  input logic [VEC_W-1:0]     out_vector,
  input logic                 out_level
);
  assert_first_inj_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (is_fixed || is_lowest) && (tgt_mask != '0) |=> out_valid);

  assert_empty_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (tgt_mask == '0) |=> !out_valid && req_ready);

  assert_mode_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_fixed && !is_lowest |=> !out_valid);

  assert_single_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_lowest && (tgt_mask != '0) |=> $countones(pend_mask) == 1);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot)
      && $stable(out_vector) && $stable(out_level));

  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && ($countones(pend_mask) > 1) |=> out_valid && (out_slot > $past(out_slot)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && ($countones(pend_mask) == 1) |=> req_ready);
endmodule

bind irq_dest_dispatch irq_dd_checker #(
  .NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .is_fixed   (is_fixed),
  .is_lowest  (is_lowest),
  .tgt_mask   (tgt_mask),
  .pend_mask  (pend_mask),
  .req_ready  (req_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_fire   (out_fire),
  .out_slot   (out_slot),
  .out_vector (out_vector),
  .out_level  (out_level)
);

// File: tb/irq_dest_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dest_dispatch_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [7:0]   req_dest = '0;
  logic         req_logical = 1'b0;
  logic [2:0]   req_dmode = '0;
  logic [7:0]   req_vector = '0;
  logic         req_level = 1'b0;
  logic [N-1:0] slot_present = '0;
  logic [N*8-1:0] slot_phys_id = '0;
  logic [N*8-1:0] slot_log_id = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [3:0]   out_slot;
  logic [7:0]   out_vector;
  logic         out_level;

  always #2.5 clk = ~clk;

  irq_dest_dispatch u_irq_dest_dispatch (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dest(req_dest),
    .req_logical(req_logical), .req_dmode(req_dmode), .req_vector(req_vector),
    .req_level(req_level), .slot_present(slot_present),
    .slot_phys_id(slot_phys_id), .slot_log_id(slot_log_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
    .out_vector(out_vector), .out_level(out_level)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    stall_on = 1'b0;
  bit    done = 1'b0;

  // ---------------- reference model ----------------
  int   exp_q[$];
  int   rr = 0;
  logic [7:0] m_vec = '0;
  logic       m_lvl = 1'b0;

  function automatic int phys_of(int s);
    return int'(slot_phys_id[s*8 +: 8]);
  endfunction
  function automatic int log_of(int s);
    return int'(slot_log_id[s*8 +: 8]);
  endfunction

  function automatic bit [N-1:0] ref_targets(int dest, bit logical);
    bit [N-1:0] t = '0;
    if (!logical) begin
      if (dest == 255) return slot_present;
      for (int s = 0; s < N; s++)
        if (slot_present[s] && phys_of(s) == dest) begin
          t[s] = 1'b1;
          return t;
        end
      return t;
    end
    if (dest == 0) return t;
    for (int s = 0; s < N; s++)
      if (slot_present[s] && ((log_of(s) & dest) != 0)) t[s] = 1'b1;
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      rr = 0;
    end else if (exp_q.size() > 0) begin
      if (out_ready) void'(exp_q.pop_front());
    end else if (req_valid) begin
      bit [N-1:0] t;
      t = ref_targets(int'(req_dest), req_logical);
      m_vec = req_vector;
      m_lvl = req_level;
      if (req_dmode == 3'd0) begin
        for (int s = 0; s < N; s++) if (t[s]) exp_q.push_back(s);
      end else if (req_dmode == 3'd1) begin
        for (int k = 0; k < N; k++) begin
          int s;
          s = (rr + k) % N;
          if (t[s]) begin
            exp_q.push_back(s);
            rr = (s + 1) % N;
            break;
          end
        end
      end
    end
  end

  task automatic check(string tag, string what, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = exp_q.size() > 0;
      check(cur_tag, "out_valid", int'(out_valid), int'(ev));
      check("R9", "req_ready", int'(req_ready), int'(!ev));
      if (ev && out_valid) begin
        check(cur_tag, "out_slot", int'(out_slot), exp_q[0]);
        check("R6", "out_vector", int'(out_vector), int'(m_vec));
        check("R6", "out_level", int'(out_level), int'(m_lvl));
      end
    end
  end

  always @(negedge clk) out_ready = stall_on ? 1'($urandom % 2) : 1'b1;

  // ---------------- stimulus ----------------
  task automatic set_slot(int s, bit p, int ph, int lg);
    slot_present[s] = p;
    slot_phys_id[s*8 +: 8] = 8'(ph);
    slot_log_id[s*8 +: 8]  = 8'(lg);
  endtask

  task automatic send(string tag, int dest, bit logical, int dmode, int vec, bit lvl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    req_dest = 8'(dest); req_logical = logical; req_dmode = 3'(dmode);
    req_vector = 8'(vec); req_level = lvl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < N; s++) set_slot(s, 1'b1, 32 + s, 1 << (s % 8));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset out_valid", int'(out_valid), 0);
    check("R1", "reset req_ready", int'(req_ready), 1);

    // R1 + R7: logical 0x21 targets {0,5,8,13}; rotation from slot 0 and wrap
    send("R1", 8'h21, 1'b1, 1, 8'h40, 1'b1);
    for (int i = 0; i < 4; i++) send("R7", 8'h21, 1'b1, 1, 8'h41 + i, 1'b0);

    // R2 + R6 + R10: broadcast fixed with absent slots and stalls
    set_slot(3, 1'b0, 35, 8);
    set_slot(7, 1'b0, 39, 128);
    stall_on = 1'b1;
    send("R2", 8'hFF, 1'b0, 0, 8'h55, 1'b1);
    send("R10", 8'hFF, 1'b0, 0, 8'h56, 1'b0);
    stall_on = 1'b0;

    // R3: duplicate physical IDs, first present match only
    set_slot(9, 1'b1, 36, 2);
    send("R3", 36, 1'b0, 0, 8'h60, 1'b0);
    set_slot(4, 1'b0, 36, 16);
    send("R3", 36, 1'b0, 0, 8'h61, 1'b1);
    send("R3", 35, 1'b0, 0, 8'h62, 1'b0);   // matches only an absent slot

    // R5: no physical match; R4: logical zero and multi-match
    send("R5", 8'h99, 1'b0, 0, 8'h70, 1'b0);
    send("R4", 8'h00, 1'b1, 0, 8'h71, 1'b0);
    send("R4", 8'h06, 1'b1, 0, 8'h72, 1'b1);
    send("R5", 8'h00, 1'b1, 1, 8'h73, 1'b0);

    // R8: unsupported delivery modes
    for (int d = 2; d < 8; d++) send("R8", 8'hFF, 1'b0, d, 8'h80 + d, 1'b1);

    // R11 / R9: random traffic with stalls and table changes
    stall_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 4);
      if (r == 0) set_slot(int'($urandom % N), 1'($urandom), int'($urandom % 8) + 32,
                           int'($urandom % 256));
      send("R11", (($urandom % 3) == 0) ? 255 : int'($urandom % 48),
           1'($urandom), int'($urandom % 3), int'($urandom % 256), 1'($urandom));
    end
    stall_on = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule